// File: doc/BRIEF.md
# Inter-processor interrupt control register

This block is a 64-bit write-and-read control register inside a chipset that serves up to four processors. Any processor may write it to raise an inter-processor interrupt towards one or more processors, and each processor writes it to acknowledge the interrupt that was raised towards it. A single pending bit per processor records an interrupt that has been raised but not yet acknowledged. That bit drives a dedicated registered interrupt line at one fixed level, separate from the timer interrupt lines.

The same register also holds one timer-interrupt status bit per processor. A timer event input sets the bit and a software write clears it. A write that carries no recognised field is refused: the register state stays as it was and a one-cycle error pulse follows. One bit of the write data is defined as accepted with no effect, so a write carrying only that bit is not refused.

Top module: `ipi_ctl_reg`

## Requirements
- R1: While rst_n is low, every pending bit, every timer status bit, irq_ipi, irq_tmr and wr_err are zero, and they stay zero until a write or a timer event after rst_n has gone high.
- R2: A write with wr_data bit 12+n set (request field, n = 0..3) sets pending bit n, and irq_ipi[n] is high from the clock edge that takes the write.
- R3: A request to a processor whose pending bit is already set is dropped and not counted: a single acknowledge clears it afterwards.
- R4: A write with wr_data bit 8+n set (acknowledge field) clears pending bit n, and irq_ipi[n] is low from that clock edge. An acknowledge to a processor that is not pending changes nothing.
- R5: Request and acknowledge in one write are both applied, the request first. The same processor in both fields therefore ends up not pending, and different processors each get their own action.
- R6: tmr_evt[n] high at a clock edge sets timer status bit n, so irq_tmr[n] is high from that edge. A write with wr_data bit 4+n set clears it. When an event and a clear for the same processor fall at one edge, the event wins. Timer activity never changes irq_ipi.
- R7: A write whose only recognised content is wr_data bit 28 is accepted: no error is raised and no state changes.
- R8: A write in which the request field, the acknowledge field, the timer-clear field and bit 28 are all zero raises wr_err for exactly the one cycle after the write edge, and leaves all pending and timer state unchanged.
- R9: rd_data bits 11:8 show the pending bits, bits 7:4 show the timer status bits, and all other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 64 | Write data: timer clear bits 7:4, acknowledge bits 11:8, request bits 15:12, accepted no-effect bit 28 |
| tmr_evt | input | 4 | Per-processor timer event, sets timer status |
| rd_data | output | 64 | Register read value |
| irq_ipi | output | 4 | Per-processor inter-processor interrupt line |
| irq_tmr | output | 4 | Per-processor timer interrupt line |
| wr_err | output | 1 | One-cycle pulse after an unsupported write |

## Verification
A request and an acknowledge can reach the pending bits in the same write, and a timer clear can meet a timer event at the same edge. Both cases are provoked by driving the two fields, or the field and the event input, in the same cycle, once for the same processor and once for different processors. The result is judged on the interrupt lines and the read value one edge later. A same-processor request and acknowledge must leave the line low whether or not it was pending before. A simultaneous timer clear and event must leave the timer line high.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned IPI_CPUS_MAX = 4;
  localparam int unsigned REG_BITS     = 64;
  localparam int unsigned TCLR_LSB     = 4;
  localparam int unsigned ACK_LSB      = 8;
  localparam int unsigned REQ_LSB      = 12;
  localparam int unsigned NOP_BIT      = 28;
endpackage

// File: rtl/ipi_field_decode.sv
module ipi_field_decode
  import ipi_pkg::*;
#(
  parameter int unsigned NCPU  = IPI_CPUS_MAX,
  parameter int unsigned REG_W = REG_BITS
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [NCPU-1:0]  req,
  output logic [NCPU-1:0]  ack,
  output logic [NCPU-1:0]  tclr,
  output logic             bad_wr
);
  logic [NCPU-1:0] req_f, ack_f, tclr_f;
  logic            nop_f, any_f;

  always_comb begin
    req_f  = wr_data[REQ_LSB  +: NCPU];
    ack_f  = wr_data[ACK_LSB  +: NCPU];
    tclr_f = wr_data[TCLR_LSB +: NCPU];
    nop_f  = wr_data[NOP_BIT];
    any_f  = (|req_f) | (|ack_f) | (|tclr_f) | nop_f;
    req    = wr_en ? req_f  : '0;
    ack    = wr_en ? ack_f  : '0;
    tclr   = wr_en ? tclr_f : '0;
    bad_wr = wr_en & ~any_f;
  end
endmodule

// File: rtl/ipi_pending_bank.sv
module ipi_pending_bank #(
  parameter int unsigned NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] req,
  input  logic [NCPU-1:0] ack,
  output logic [NCPU-1:0] pend
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic pend_q, pend_d, pend_en;

    // request applied first, acknowledge second
    always_comb begin
      pend_en = req[c] | ack[c];
      pend_d  = (pend_q | req[c]) & ~ack[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (pend_en) pend_q <= pend_d;
    end

    assign pend[c] = pend_q;
  end
endmodule

// File: rtl/tmr_status_bank.sv
module tmr_status_bank #(
  parameter int unsigned NCPU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] evt,
  input  logic [NCPU-1:0] tclr,
  output logic [NCPU-1:0] tstat
);
  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic st_q, st_d, st_en;

    // an event at the same edge as a clear is kept
    always_comb begin
      st_en = evt[c] | tclr[c];
      st_d  = evt[c] | (st_q & ~tclr[c]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= 1'b0;
      else if (st_en) st_q <= st_d;
    end

    assign tstat[c] = st_q;
  end
endmodule

// File: rtl/ipi_ctl_reg.sv
module ipi_ctl_reg
  import ipi_pkg::*;
#(
  parameter int unsigned NCPU  = IPI_CPUS_MAX,
  parameter int unsigned REG_W = REG_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [NCPU-1:0]  tmr_evt,
  output logic [REG_W-1:0] rd_data,
  output logic [NCPU-1:0]  irq_ipi,
  output logic [NCPU-1:0]  irq_tmr,
  output logic             wr_err
);
  logic [NCPU-1:0] req, ack, tclr, pend, tstat;
  logic            bad_wr, err_q;

  ipi_field_decode #(.NCPU(NCPU), .REG_W(REG_W)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .req     (req),
    .ack     (ack),
    .tclr    (tclr),
    .bad_wr  (bad_wr)
  );

  ipi_pending_bank #(.NCPU(NCPU)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .ack   (ack),
    .pend  (pend)
  );

  tmr_status_bank #(.NCPU(NCPU)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (tmr_evt),
    .tclr  (tclr),
    .tstat (tstat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= bad_wr;
  end

  always_comb begin
    rd_data = '0;
    rd_data[ACK_LSB  +: NCPU] = pend;
    rd_data[TCLR_LSB +: NCPU] = tstat;
  end

  assign irq_ipi = pend;
  assign irq_tmr = tstat;
  assign wr_err  = err_q;
endmodule

// File: rtl/ipi_ctl_reg_chk.sv
module ipi_ctl_reg_chk
  import ipi_pkg::*;
#(
  parameter int unsigned NCPU  = IPI_CPUS_MAX,
  parameter int unsigned REG_W = REG_BITS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [NCPU-1:0]  tmr_evt,
  input logic [REG_W-1:0] rd_data,
  input logic [NCPU-1:0]  irq_ipi,
  input logic [NCPU-1:0]  irq_tmr,
  input logic             wr_err
);
  logic any_field;
  assign any_field = (|wr_data[REQ_LSB +: NCPU]) | (|wr_data[ACK_LSB +: NCPU])
                   | (|wr_data[TCLR_LSB +: NCPU]) | wr_data[NOP_BIT];

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    // R2
    req_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[REQ_LSB+c] && !wr_data[ACK_LSB+c] |=> irq_ipi[c]);
    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[ACK_LSB+c] |=> !irq_ipi[c]);
    // R6
    tmr_evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_evt[c] |=> irq_tmr[c]);
  end

  // R8
  bad_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !any_field |=> wr_err);
  // R8
  bad_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !any_field |=> $stable(irq_ipi));
  // R7
  nop_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[NOP_BIT] |=> !wr_err);
  // R8
  err_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !wr_err);
  // R6
  ipi_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(irq_ipi));
  // R9
  read_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[ACK_LSB +: NCPU] == irq_ipi && rd_data[TCLR_LSB +: NCPU] == irq_tmr);
endmodule

bind ipi_ctl_reg ipi_ctl_reg_chk #(.NCPU(NCPU), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .tmr_evt(tmr_evt), .rd_data(rd_data), .irq_ipi(irq_ipi),
  .irq_tmr(irq_tmr), .wr_err(wr_err)
);

// File: tb/ipi_ctl_reg_test.sv
`timescale 1ns/1ps
module ipi_ctl_reg_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [3:0]  tmr_evt;
  logic [63:0] rd_data;
  logic [3:0]  irq_ipi, irq_tmr;
  logic        wr_err;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ipi_ctl_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tmr_evt(tmr_evt), .rd_data(rd_data), .irq_ipi(irq_ipi),
    .irq_tmr(irq_tmr), .wr_err(wr_err)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] d;
    logic [3:0]  te;
    logic [3:0]  eipi;
    logic [3:0]  etmr;
    logic        eerr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_1000, 4'h0, 4'h1, 4'h0, 1'b0}, // R2 request cpu0
    '{1'b1, 32'h0000_3000, 4'h0, 4'h3, 4'h0, 1'b0}, // R3 cpu0 again, cpu1 new
    '{1'b1, 32'h0000_0100, 4'h0, 4'h2, 4'h0, 1'b0}, // R3 one ack clears cpu0
    '{1'b1, 32'h0000_0100, 4'h0, 4'h2, 4'h0, 1'b0}, // R4 ack of non-pending
    '{1'b1, 32'h0000_0001, 4'h0, 4'h2, 4'h0, 1'b1}, // R8 unsupported write
    '{1'b0, 32'h0000_0000, 4'h5, 4'h2, 4'h5, 1'b0}, // R6 timer events, R8 pulse ends
    '{1'b1, 32'h0000_0010, 4'h0, 4'h2, 4'h4, 1'b0}, // R6 clear timer cpu0
    '{1'b1, 32'h0000_8400, 4'h0, 4'hA, 4'h4, 1'b0}, // R5 req cpu3, ack cpu2
    '{1'b1, 32'h0000_4400, 4'h0, 4'hA, 4'h4, 1'b0}, // R5 req+ack cpu2
    '{1'b1, 32'h1000_0000, 4'h0, 4'hA, 4'h4, 1'b0}, // R7 no-effect bit
    '{1'b1, 32'h0000_0040, 4'h4, 4'hA, 4'h4, 1'b0}, // R6 event beats clear
    '{1'b1, 32'h0000_0A40, 4'h0, 4'h0, 4'h0, 1'b0}, // R4 ack 1,3 and clear 2
    '{1'b1, 32'h0000_F000, 4'h0, 4'hF, 4'h0, 1'b0}, // R2 all cpus
    '{1'b1, 32'h0000_0F00, 4'h3, 4'h0, 4'h3, 1'b0}  // R4 ack all, R6 events
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [3:0] eipi,
                         input logic [3:0] etmr, input logic eerr);
    chk({tag, " irq_ipi"}, {60'b0, irq_ipi}, {60'b0, eipi});
    chk({tag, " irq_tmr"}, {60'b0, irq_tmr}, {60'b0, etmr});
    chk({tag, " wr_err"},  {63'b0, wr_err},  {63'b0, eerr});
    chk("R9 rd_data", rd_data, {52'b0, eipi, etmr, 4'b0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tmr_evt = '0;
    repeat (3) @(negedge clk);
    chk_all("R1 reset", 4'h0, 4'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after release", 4'h0, 4'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      wr_en   = VECS[i].wr;
      wr_data = {32'b0, VECS[i].d};
      tmr_evt = VECS[i].te;
      @(negedge clk);
      chk_all($sformatf("R2-vector %0d", i), VECS[i].eipi, VECS[i].etmr, VECS[i].eerr);
    end

    // R8: write with only an unrecognised upper bit and a low bit
    wr_en = 1'b1; wr_data = 64'h0000_0000_0000_1000; tmr_evt = '0;
    @(negedge clk);
    chk_all("R2 setup", 4'h1, 4'h3, 1'b0);
    wr_data = (64'h1 << 40) | 64'h4;
    @(negedge clk);
    chk_all("R8 upper-bit write", 4'h1, 4'h3, 1'b1);
    wr_en = 1'b0; wr_data = '0;
    @(negedge clk);
    chk_all("R8 single pulse", 4'h1, 4'h3, 1'b0);

    // R1: asynchronous reset away from the edge
    #1 rst_n = 1'b0;
    #0.5;
    chk_all("R1 async reset", 4'h0, 4'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 idle after reset", 4'h0, 4'h0, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule